// File: doc/BRIEF.md
# DMA Page Translation Walker

This block turns a 32-bit address issued by a DMA device into a physical memory address by looking it up in a flat, single-level page table that lives in system memory. Pages are 4096 bytes. Software first loads a table base and a table size (in bytes) through a small configuration write port; after that, each request presented on a valid/ready handshake is checked against the table size, and if it falls inside the table, the block fetches the corresponding two-word entry over a word-wide memory read port.

The first word of an entry holds the physical frame; the second word carries ownership information that this block fetches but does not interpret. The response reports the physical frame joined with the untouched page offset, along with read and write permission, or a fault with a zero address and no permission when the index is out of range or memory reports an error. Only one translation is in flight at a time.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset the table base and table size are zero and `req_ready` is high, `rsp_valid` and `mem_req` are low; every translation then faults without any memory read.
- R2: The page index is `req_addr >> 12` and the page offset is `req_addr[11:0]`; on success `rsp_paddr` is `{frame[31:12], offset}`, where frame is the first word fetched.
- R3: A request is in range only when its page index is strictly less than the table size divided by 8 (size >> 3, remainder dropped); an out-of-range request faults and issues no memory read.
- R4: The entry address is `{1'b0, base[30:0]} + index*8` modulo 2^32; the frame word is read at that address and the owner word is read at that address plus 4, frame first.
- R5: Each memory word is requested by a single-cycle `mem_req` pulse, and the second word is requested only after `mem_rvalid` has returned the first.
- R6: If `mem_rerr` is set on either returned word, the response is a fault with `rsp_paddr` zero and `rsp_perm` zero.
- R7: A successful translation returns `rsp_fault` low and `rsp_perm` = 2'b11 (bit 0 read allowed, bit 1 write allowed).
- R8: `req_ready` is high only while no translation is in progress; it drops in the cycle after a request is accepted and returns in the cycle after the response.
- R9: Each accepted request produces exactly one response, signalled by `rsp_valid` high for a single cycle.
- R10: A configuration write with `cfg_sel` = 0 loads the table base and with `cfg_sel` = 1 loads the table size; the new value applies to every request accepted after the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects table size |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_addr | input | 32 | Device DMA address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_perm | output | 2 | Granted permission, bit 0 read, bit 1 write |
| rsp_paddr | output | 32 | Translated physical address, zero on fault |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data word |
| mem_rerr | input | 1 | Memory read error for this word |

## Verification
On every cycle the assertions check the shape of the responses and memory requests: a fault never carries an address or permission, a success always carries both permissions, the response and memory-request strobes last one cycle, the block is never ready while responding, and an out-of-range request is never followed by a read. Whether the right entry address was formed, whether the frame bits and offset were joined correctly, and whether the range test sits exactly at the limit can only be shown by the bench's scenarios, which compare against a memory model whose word contents depend on the address read. Error injection on each word and a slow memory show the fault path and the wait behaviour.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    W_IDLE,
    W_FRAME,
    W_OWNER,
    W_RESP
  } walk_state_e;

  localparam int PERM_RD_BIT = 0;
  localparam int PERM_WR_BIT = 1;
  localparam int PERM_W      = 2;
endpackage

// File: rtl/xlate_cfg_regs.sv
module xlate_cfg_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] tbl_base,
  output logic [AW-1:0] tbl_size
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_base <= '0;
      tbl_size <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) tbl_size <= cfg_wdata;
      else         tbl_base <= cfg_wdata;
    end
  end
endmodule

// File: rtl/xlate_entry_calc.sv
module xlate_entry_calc #(
  parameter int AW          = 32,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_BYTES = 8
) (
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] tbl_size,
  output logic          in_range,
  output logic [AW-1:0] entry_addr
);
  localparam int ES = $clog2(ENTRY_BYTES);
  localparam int IW = AW - PAGE_BITS;

  logic [IW-1:0] page_idx;
  logic [AW-1:0] idx_wide;
  logic [AW-1:0] n_entries;
  logic [AW-1:0] base_low;

  assign page_idx   = vaddr[AW-1:PAGE_BITS];
  assign idx_wide   = {{PAGE_BITS{1'b0}}, page_idx};
  assign n_entries  = tbl_size >> ES;
  assign in_range   = (idx_wide < n_entries);
  assign base_low   = {1'b0, tbl_base[AW-2:0]};
  assign entry_addr = base_low + (idx_wide << ES);
endmodule

// File: rtl/xlate_walk_fsm.sv
module xlate_walk_fsm
  import xlate_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PAGE_BITS  = 12,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  output logic              req_ready,
  input  logic              in_range,
  input  logic [AW-1:0]     entry_addr,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [AW-1:0]     mem_rdata,
  input  logic              mem_rerr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PERM_W-1:0] rsp_perm,
  output logic [AW-1:0]     rsp_paddr
);
  walk_state_e          state;
  logic [PAGE_BITS-1:0] off_q;
  logic [AW-1:0]        frame_q;
  logic                 err_q;
  logic                 accept;
  logic                 bad;

  assign req_ready = (state == W_IDLE);
  assign accept    = req_valid && req_ready;
  assign bad       = err_q || mem_rerr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= W_IDLE;
      off_q     <= '0;
      frame_q   <= '0;
      err_q     <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_perm  <= '0;
      rsp_paddr <= '0;
    end else begin
      mem_req   <= 1'b0;
      rsp_valid <= 1'b0;
      case (state)
        W_IDLE: begin
          if (req_valid) begin
            off_q <= req_addr[PAGE_BITS-1:0];
            if (in_range) begin
              mem_addr <= entry_addr;
              mem_req  <= 1'b1;
              state    <= W_FRAME;
            end else begin
              rsp_fault <= 1'b1;
              rsp_perm  <= '0;
              rsp_paddr <= '0;
              rsp_valid <= 1'b1;
              state     <= W_RESP;
            end
          end
        end
        W_FRAME: begin
          if (mem_rvalid) begin
            frame_q  <= mem_rdata;
            err_q    <= mem_rerr;
            mem_addr <= mem_addr + AW'(WORD_BYTES);
            mem_req  <= 1'b1;
            state    <= W_OWNER;
          end
        end
        W_OWNER: begin
          if (mem_rvalid) begin
            rsp_valid <= 1'b1;
            rsp_fault <= bad;
            if (bad) begin
              rsp_perm  <= '0;
              rsp_paddr <= '0;
            end else begin
              rsp_perm[PERM_RD_BIT] <= 1'b1;
              rsp_perm[PERM_WR_BIT] <= 1'b1;
              rsp_paddr <= {frame_q[AW-1:PAGE_BITS], off_q};
            end
            state <= W_RESP;
          end
        end
        default: begin
          state <= W_IDLE;
        end
      endcase
    end
  end

  // R6: a fault never carries an address or permission
  assert_fault_clean_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_perm == '0));

  // R7: success grants read and write
  assert_ok_perm_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_perm == 2'b11));

  // R8: never ready while a response is being presented
  assert_busy_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  // R9: the response strobe lasts one cycle
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R5: memory request strobe lasts one cycle
  assert_req_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R3: an out-of-range request issues no read
  assert_oob_no_read_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_range) |=> (!mem_req && rsp_valid && rsp_fault));
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import xlate_pkg::*;
#(
  parameter int AW          = 32,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_BYTES = 8,
  parameter int WORD_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PERM_W-1:0] rsp_perm,
  output logic [AW-1:0]     rsp_paddr,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [AW-1:0]     mem_rdata,
  input  logic              mem_rerr
);
  logic [AW-1:0] tbl_base;
  logic [AW-1:0] tbl_size;
  logic          in_range;
  logic [AW-1:0] entry_addr;

  xlate_cfg_regs #(.AW(AW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .tbl_base  (tbl_base),
    .tbl_size  (tbl_size)
  );

  xlate_entry_calc #(
    .AW          (AW),
    .PAGE_BITS   (PAGE_BITS),
    .ENTRY_BYTES (ENTRY_BYTES)
  ) u_calc (
    .vaddr      (req_addr),
    .tbl_base   (tbl_base),
    .tbl_size   (tbl_size),
    .in_range   (in_range),
    .entry_addr (entry_addr)
  );

  xlate_walk_fsm #(
    .AW         (AW),
    .PAGE_BITS  (PAGE_BITS),
    .WORD_BYTES (WORD_BYTES)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .in_range   (in_range),
    .entry_addr (entry_addr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_rerr   (mem_rerr),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_perm   (rsp_perm),
    .rsp_paddr  (rsp_paddr)
  );
endmodule

// File: tb/test_dma_xlate_walker.sv
`timescale 1ns/1ps
module test_dma_xlate_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_perm;
  logic [31:0] rsp_paddr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_rerr = 1'b0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dma_xlate_walker i_dma_xlate_walker (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_perm(rsp_perm), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rerr(mem_rerr)
  );

  // memory model
  int          lat = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_at = '0;
  logic        m_busy = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_addr = '0;
  int          rd_cnt = 0;
  logic [31:0] rd_log [2];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h0001_0193) ^ 32'hC0DE_0000;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      if (rd_cnt < 2) rd_log[rd_cnt] = mem_addr;
      rd_cnt = rd_cnt + 1;
      m_addr <= mem_addr;
      m_cnt  <= lat;
      m_busy <= 1'b1;
    end else if (m_busy) begin
      if (m_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_word(m_addr);
        mem_rerr   <= err_en && (m_addr == err_at);
        m_busy     <= 1'b0;
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] sw_base = '0;
  logic [31:0] sw_size = '0;

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) sw_size = d; else sw_base = d;
  endtask

  task automatic xlate(input logic [31:0] va, input string tag);
    logic [31:0] idx, ent, exp_pa;
    logic        inr, flt;
    int          n;
    idx = va >> 12;
    inr = idx < (sw_size >> 3);
    ent = {1'b0, sw_base[30:0]} + (idx << 3);
    flt = !inr || (err_en && (err_at == ent || err_at == ent + 32'd4));
    exp_pa = flt ? 32'h0 : {mem_word(ent)[31:12], va[11:0]};
    rd_cnt = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R8 busy after accept"}, {31'b0, req_ready}, 32'd0);
    n = 0;
    while (!rsp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " R9 response seen"}, {31'b0, rsp_valid}, 32'd1);
    chk({tag, " R3/R6 fault"}, {31'b0, rsp_fault}, {31'b0, flt});
    chk({tag, " R2 paddr"}, rsp_paddr, exp_pa);
    chk({tag, " R7 perm"}, {30'b0, rsp_perm}, flt ? 32'd0 : 32'd3);
    chk({tag, " R5 read count"}, rd_cnt, inr ? 32'd2 : 32'd0);
    if (inr) begin
      chk({tag, " R4 frame addr"}, rd_log[0], ent);
      chk({tag, " R4 owner addr"}, rd_log[1], ent + 32'd4);
    end
    @(negedge clk);
    chk({tag, " R9 single pulse"}, {31'b0, rsp_valid}, 32'd0);
    chk({tag, " R8 ready again"}, {31'b0, req_ready}, 32'd1);
  endtask

  // base, size, address
  localparam logic [95:0] VEC [7] = '{
    {32'h0001_0000, 32'h0000_0040, 32'h0000_3ABC},
    {32'h0001_0000, 32'h0000_0040, 32'h0000_7FFF},
    {32'h0001_0000, 32'h0000_0040, 32'h0000_8000},
    {32'h8002_0000, 32'h0000_1000, 32'h0012_3456},
    {32'h0004_0000, 32'h0000_0047, 32'h0000_8010},
    {32'h0004_0000, 32'h0000_0047, 32'h0000_7001},
    {32'hFFFF_F000, 32'hFFFF_FFFF, 32'hFFFF_F123}
  };

  initial begin
    #(5.0 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'b0, req_ready}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R1 rsp idle", {31'b0, rsp_valid}, 32'd0);
    chk("R1 mem idle", {31'b0, mem_req}, 32'd0);
    xlate(32'h0000_0123, "R1 unprogrammed");

    // table walk, R10 applies each new configuration
    for (int i = 0; i < 7; i++) begin
      cfg_write(1'b0, VEC[i][95:64]);
      cfg_write(1'b1, VEC[i][63:32]);
      xlate(VEC[i][31:0], $sformatf("R10 vec%0d", i));
    end

    // slow memory
    cfg_write(1'b0, 32'h0010_0000);
    cfg_write(1'b1, 32'h0000_0100);
    lat = 3;
    xlate(32'h0000_5A5A, "R5 slow memory");
    lat = 0;

    // error on frame word
    err_en = 1'b1;
    err_at = 32'h0010_0000 + 32'd16;
    xlate(32'h0000_2FFF, "R6 frame error");
    // error on owner word
    err_at = 32'h0010_0000 + 32'd28;
    xlate(32'h0000_3001, "R6 owner error");
    err_en = 1'b0;
    xlate(32'h0000_3001, "R7 recovered");

    // exact limit boundary: size 0x100 -> 32 entries
    xlate(32'h0001_F000, "R3 last index");
    xlate(32'h0002_0000, "R3 first outside");

    // reset clears configuration
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sw_base = '0;
    sw_size = '0;
    xlate(32'h0000_1000, "R1 after second reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule